// File: doc/BRIEF.md
# Partitionable 64-bit Add/Subtract Lane

This block is a 64-bit adder/subtractor. A mode input sets how the datapath is divided. It can work as one 64-bit unit, as two 32-bit units or as eight 8-bit units. All sub-units take their operands from the same two 64-bit input words and write into the same 64-bit result word. The datapath is built from eight byte-wide adder slices. In the split modes the carry chain is cut wherever a sub-unit begins, so no carry or borrow crosses from one sub-unit into the next. Each sub-unit also reports its carry-out.

Operands arrive on a valid/ready input stream, and results leave on a valid/ready output stream through a single output register. A transfer that is accepted in one cycle shows up on the output in the next cycle.

The enable input works differently in each mode. In 32-bit mode each half has its own enable bit. In 64-bit mode and 8-bit mode a single bit controls the whole word. A disabled sub-unit keeps the result and carry it held before.

Back-pressure rules:
- The input is accepted whenever the output register is empty or is being drained in the same cycle.
- While the output is valid and not taken, the output holds steady and no new input is accepted.

Top module: `split_add_lane`

## Requirements
- R1: With `mode` 2'b00 (and also the reserved code 2'b11), the block computes one 64-bit result. The result is `a + b` when `op_sub` = 0 and `a - b` when `op_sub` = 1, modulo 2^64.
- R2: With `mode` 2'b01, bits 31:0 and bits 63:32 are computed as two independent 32-bit add/subtract results. No carry or borrow passes between bit 31 and bit 32.
- R3: With `mode` 2'b10, each byte (bits 8k+7:8k) is an independent 8-bit add/subtract. No carry or borrow passes between bytes.
- R4: `carry[i]` is the carry-out of sub-unit i, where sub-unit 0 is the least significant. For subtraction the flag is 1 when no borrow occurred. Bit 0 is used in 64-bit mode, bits 1:0 in 32-bit mode and bits 7:0 in 8-bit mode. Every other carry bit reads 0 after any accepted transfer.
- R5: In 32-bit mode, `en[0]` gates the write of bits 31:0 and `carry[0]`, and `en[1]` gates the write of bits 63:32 and `carry[1]`.
- R6: In 64-bit mode and in 8-bit mode, only `en[0]` gates the write, and it gates the whole word and all used carry bits together. `en[1]` has no effect in these modes.
- R7: A disabled sub-unit keeps its previous result bits and carry bit across an accepted transfer.
- R8: A transfer occurs when `in_valid` and `in_ready` are both high. `out_valid` is high in the following cycle, and `res`/`carry` then show that transfer's outcome.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `res`, `carry` and `out_valid` stay unchanged.
- R10: After reset, `out_valid`, `res` and `carry` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Block can accept an operand word |
| op_a | input | 64 | First operand (minuend) |
| op_b | input | 64 | Second operand (subtrahend) |
| op_sub | input | 1 | 1 selects subtraction, 0 addition |
| mode | input | 2 | 00/11 one 64-bit unit, 01 two 32-bit, 10 eight 8-bit |
| en | input | 2 | Sub-unit write enables (meaning per mode, see R5/R6) |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Downstream takes the result |
| res | output | 64 | Registered result word |
| carry | output | 8 | Registered per-sub-unit carry flags |

## Verification
Two events can fall in the same clock edge: a held result being drained by `out_ready`, and a new operand word being accepted. In that case the register must swap in the new value without a bubble and without losing it. The bench provokes this by stalling the output with `out_ready` low while a second operand word waits on the input, and then raising `out_ready`. It judges the outcome at the ports, with these checks:
- During the stall the first result stays on the output and `in_ready` stays low.
- After that single edge, the second word's result is present and `out_valid` is still high.
- One cycle later, with no new input, `out_valid` falls.

// File: rtl/sal_pkg.sv
package sal_pkg;
  localparam int LANE_W  = 8;
  localparam int N_LANES = 8;
  localparam int WORD_W  = LANE_W * N_LANES;
  localparam int HALF    = N_LANES / 2;

  typedef enum logic [1:0] {
    PM_FULL = 2'b00,
    PM_HALF = 2'b01,
    PM_BYTE = 2'b10,
    PM_RSVD = 2'b11
  } part_mode_e;
endpackage

// File: rtl/sal_slice.sv
module sal_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W-1:0] b_eff;
  assign b_eff = b ^ {W{sub}};
  assign {cout, s} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
endmodule

// File: rtl/sal_part_ctrl.sv
module sal_part_ctrl
  import sal_pkg::*;
#(
  parameter int NL = N_LANES
) (
  input  part_mode_e    pmode,
  input  logic [1:0]    en,
  output logic [NL-1:0] cut,
  output logic [NL-1:0] lane_we,
  output logic [NL-1:0] flag_used,
  output logic [NL-1:0] flag_we
);
  localparam int HL = NL / 2;

  always_comb begin
    cut       = '0;
    lane_we   = '0;
    flag_used = '0;
    flag_we   = '0;
    cut[0]    = 1'b1;
    case (pmode)
      PM_HALF: begin
        cut[HL]      = 1'b1;
        flag_used[0] = 1'b1;
        flag_used[1] = 1'b1;
        flag_we[0]   = en[0];
        flag_we[1]   = en[1];
        for (int k = 0; k < NL; k++)
          lane_we[k] = (k < HL) ? en[0] : en[1];
      end
      PM_BYTE: begin
        cut       = '1;
        lane_we   = {NL{en[0]}};
        flag_used = '1;
        flag_we   = {NL{en[0]}};
      end
      default: begin
        lane_we      = {NL{en[0]}};
        flag_used[0] = 1'b1;
        flag_we[0]   = en[0];
      end
    endcase
  end
endmodule

// File: rtl/sal_flag_map.sv
module sal_flag_map
  import sal_pkg::*;
#(
  parameter int NL = N_LANES
) (
  input  part_mode_e    pmode,
  input  logic [NL-1:0] lane_co,
  output logic [NL-1:0] flags
);
  localparam int HL = NL / 2;

  always_comb begin
    flags = '0;
    case (pmode)
      PM_HALF: begin
        flags[0] = lane_co[HL-1];
        flags[1] = lane_co[NL-1];
      end
      PM_BYTE: flags = lane_co;
      default: flags[0] = lane_co[NL-1];
    endcase
  end
endmodule

// File: rtl/split_add_lane.sv
module split_add_lane
  import sal_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NL = N_LANES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [LW*NL-1:0] op_a,
  input  logic [LW*NL-1:0] op_b,
  input  logic           op_sub,
  input  logic [1:0]     mode,
  input  logic [1:0]     en,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [LW*NL-1:0] res,
  output logic [NL-1:0]  carry
);
  localparam int DW = LW * NL;

  part_mode_e    pmode;
  logic [NL-1:0] cut, lane_we, flag_used, flag_we;
  logic [NL-1:0] lane_co, lane_ci, flags_new;
  logic [DW-1:0] sum;
  logic [DW-1:0] res_q;
  logic [NL-1:0] carry_q;
  logic          vld_q;
  logic          accept;

  assign pmode  = part_mode_e'(mode);
  assign in_ready = !vld_q || out_ready;
  assign accept = in_valid && in_ready;

  sal_part_ctrl #(.NL(NL)) u_ctrl (
    .pmode(pmode), .en(en), .cut(cut), .lane_we(lane_we),
    .flag_used(flag_used), .flag_we(flag_we)
  );

  for (genvar k = 0; k < NL; k++) begin : g_lane
    if (k == 0) begin : g_first
      assign lane_ci[k] = op_sub;
    end else begin : g_rest
      assign lane_ci[k] = cut[k] ? op_sub : lane_co[k-1];
    end
    sal_slice #(.W(LW)) u_slice (
      .a   (op_a[k*LW +: LW]),
      .b   (op_b[k*LW +: LW]),
      .sub (op_sub),
      .cin (lane_ci[k]),
      .s   (sum[k*LW +: LW]),
      .cout(lane_co[k])
    );
  end

  sal_flag_map #(.NL(NL)) u_flags (
    .pmode(pmode), .lane_co(lane_co), .flags(flags_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      carry_q <= '0;
    end else begin
      if (accept)         vld_q <= 1'b1;
      else if (out_ready) vld_q <= 1'b0;
      if (accept) begin
        for (int k = 0; k < NL; k++) begin
          if (lane_we[k]) res_q[k*LW +: LW] <= sum[k*LW +: LW];
          if (!flag_used[k])   carry_q[k] <= 1'b0;
          else if (flag_we[k]) carry_q[k] <= flags_new[k];
        end
      end
    end
  end

  assign out_valid = vld_q;
  assign res       = res_q;
  assign carry     = carry_q;
endmodule

// File: rtl/sal_chk.sv
module sal_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        op_sub,
  input logic [1:0]  mode,
  input logic [1:0]  en,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] res,
  input logic [7:0]  carry
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R8
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res) && $stable(carry))); // R9
  AST_FULL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (mode == 2'b00 || mode == 2'b11)) |=> (carry[7:1] == 7'd0)); // R4
  AST_HALF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'b01) |=> (carry[7:2] == 6'd0)); // R4
  AST_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'b01 && !en[1]) |=> (res[63:32] == $past(res[63:32]))); // R7
  AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'b10 && !en[0]) |=> $stable(res)); // R6
  AST_BYTE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'b10 && en[0] && !op_sub && op_a[7:0] == 8'hFF &&
     op_b[7:0] == 8'h01 && op_a[15:8] == 8'h00 && op_b[15:8] == 8'h00)
    |=> (res[15:0] == 16'h0000 && carry[0])); // R3
endmodule

bind split_add_lane sal_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .mode(mode), .en(en),
  .out_valid(out_valid), .out_ready(out_ready), .res(res), .carry(carry)
);

// File: tb/split_add_lane_tb.sv
`timescale 1ns/1ps
module split_add_lane_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] op_a = '0, op_b = '0;
  logic        op_sub = 1'b0;
  logic [1:0]  mode = 2'b00, en = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] res;
  logic [7:0]  carry;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] m_res = '0;
  logic [7:0]  m_c = '0;

  always #10 clk = ~clk;

  split_add_lane u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .mode(mode), .en(en),
    .out_valid(out_valid), .out_ready(out_ready), .res(res), .carry(carry)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model of the requirements
  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic sub,
                       input logic [1:0] md, input logic [1:0] e);
    int w, n;
    logic [64:0] msk, fa, fb, s;
    logic wr;
    w = (md == 2'b01) ? 32 : (md == 2'b10) ? 8 : 64;
    n = 64 / w;
    msk = (65'd1 << w) - 65'd1;
    for (int u = 0; u < n; u++) begin
      fa = ({1'b0, a} >> (u*w)) & msk;
      fb = (({1'b0, b} >> (u*w)) & msk);
      if (sub) fb = (~fb) & msk;
      s  = fa + fb + {64'd0, sub};
      wr = (md == 2'b01) ? e[u] : e[0];
      if (wr) begin
        for (int i = 0; i < w; i++) m_res[u*w+i] = s[i];
        m_c[u] = s[w];
      end
    end
    for (int u = n; u < 8; u++) m_c[u] = 1'b0;
  endtask

  task automatic push(input logic [63:0] a, input logic [63:0] b, input logic sub,
                      input logic [1:0] md, input logic [1:0] e, input string req);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = sub; mode = md; en = e;
    in_valid = 1'b1; out_ready = 1'b1;
    model(a, b, sub, md, e);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {req, " out_valid"}, {63'd0, out_valid}, 64'd1);
    chk(res === m_res, {req, " res"}, res, m_res);
    chk(carry === m_c, {req, " carry"}, {56'd0, carry}, {56'd0, m_c});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid === 1'b0 && res === 64'd0 && carry === 8'd0, "R10 reset state",
        res, 64'd0);
    chk(in_ready === 1'b1, "R9 ready when empty", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_full;
    push(64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 2'b00, 2'b01, "R1 full add");
    chk(res === 64'h0000_0001_0000_0000, "R1 carry across bit 32", res, 64'h0000_0001_0000_0000);
    push(64'd0, 64'd1, 1'b1, 2'b00, 2'b01, "R1 full sub");
    chk(res === 64'hFFFF_FFFF_FFFF_FFFF && carry === 8'h00, "R4 full borrow", res, 64'hFFFF_FFFF_FFFF_FFFF);
    push(64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 1'b0, 2'b11, 2'b01, "R1 reserved code");
    chk(carry === 8'h01, "R4 full carry out", {56'd0, carry}, 64'h1);
  endtask

  task automatic t_half;
    push(64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 2'b01, 2'b11, "R2 half add");
    chk(res === 64'd0 && carry === 8'h01, "R2 no carry into bit 32", res, 64'd0);
    push(64'h0000_0005_0000_0000, 64'h0000_0006_0000_0001, 1'b1, 2'b01, 2'b11, "R2 half sub");
    chk(carry === 8'h00, "R4 half borrow both", {56'd0, carry}, 64'd0);
  endtask

  task automatic t_byte;
    push(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1'b0, 2'b10, 2'b01, "R3 byte add");
    chk(res === 64'd0 && carry === 8'hFF, "R3 bytes isolated", res, 64'd0);
    push(64'h0010_2030_4050_6070, 64'h0011_1111_1111_1111, 1'b1, 2'b10, 2'b01, "R3 byte sub");
  endtask

  task automatic t_enables;
    push(64'h1111_1111_2222_2222, 64'h1, 1'b0, 2'b01, 2'b01, "R5 low half only");
    push(64'h3, 64'h4000_0000_0000_0000, 1'b0, 2'b01, 2'b10, "R5 high half only");
    push(64'hAAAA, 64'h5555, 1'b0, 2'b10, 2'b10, "R6 byte en1 ignored");
    push(64'hAAAA, 64'h5555, 1'b0, 2'b00, 2'b10, "R6 full en1 ignored");
    push(64'h7, 64'h8, 1'b1, 2'b01, 2'b00, "R7 both halves held");
  endtask

  task automatic t_stall;
    logic [63:0] first;
    @(negedge clk);
    op_a = 64'd100; op_b = 64'd23; op_sub = 1'b0; mode = 2'b00; en = 2'b01;
    in_valid = 1'b1; out_ready = 1'b0;
    model(64'd100, 64'd23, 1'b0, 2'b00, 2'b01);
    first = m_res;
    @(posedge clk);
    @(negedge clk);
    op_a = 64'd9; op_b = 64'd4; op_sub = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b1 && res === first, "R9 held under stall", res, first);
    chk(in_ready === 1'b0, "R9 not ready when stalled", {63'd0, in_ready}, 64'd0);
    out_ready = 1'b1;
    model(64'd9, 64'd4, 1'b1, 2'b00, 2'b01);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && res === m_res, "R8 drain and accept same edge", res, m_res);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 drains when idle", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      push({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom),
           2'($urandom), 2'($urandom), "R1 R2 R3 R4 R7 random");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_full;
    t_half;
    t_byte;
    t_enables;
    t_stall;
    t_random;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule